// File: doc/BRIEF.md
# Clock Configuration Bus Slave

This block is the serial configuration port of a clock-generation device. It watches the two lines of a two-wire management bus, SCL and SDA. Both lines have already been synchronized into a fast system clock. The block answers as a slave on the SMBus block protocol and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It holds eight configuration bytes. Their fields drive the per-output enables, the slew and amplitude selections, the PLL operating mode and the frequency selection of the clock path next to it.

A write gives a starting offset, then a byte count, then that many data bytes, which land in consecutive registers. A read sets the offset in a write phase and turns the bus around with a repeated start. The slave then returns a count byte taken from its own programmable count register, followed by registers from the offset onward until the master gives a NACK. Two strap inputs are captured while reset is held. One picks the low three bits of the slave address. The other gives the default PLL mode, which software may override.

Top module: `cfgsmb_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1101 followed by three strap-selected bits. Strap code 00 selects 011, 01 selects 100, 10 selects 101 and 11 selects 011. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R2: In a write (address LSB 0), the first byte after the address is the offset N and the second is the count X. The next X data bytes go to registers N to N+X-1 in order. The slave acknowledges every one of these bytes.
- R3: A data byte that follows the X counted bytes gets no acknowledge and changes no register.
- R4: In a read (address LSB 1, after a repeated start), the slave first sends a count byte equal to register 7 bits 4:0, with zeros above them. It then sends register N, N+1 and onward, one byte per master ACK, and stops driving after the master's NACK.
- R5: A stop after any complete byte ends the transfer. Registers written before the stop keep their new values, and the next transfer works normally.
- R6: Register 5 reads 0x03 and register 6 reads 0x44, and writes to them change nothing. Offsets 8 and above read 0x00, and writes to them change nothing.
- R7: Register 1 bits 7:6 hold the mode strap captured in reset: code 00 gives 00, 01 gives 01, 10 gives 11 and 11 gives 00. The pllMode output equals register 1 bits 4:3 when register 1 bit 5 is 1. Otherwise it equals bits 7:6.
- R8: freqSel equals register 3 bits 4:3 when register 3 bit 5 is 1, and 00 otherwise. fbSlewFast equals register 3 bit 0, which resets to 1.
- R9: Only these bits are writable: register 0 mask 0x6A, register 1 mask 0x3B, register 2 mask 0x6A, register 3 mask 0x39, register 7 mask 0x1F. The other bits keep their reset values. Reset values: register 0 0xFF, register 1 {mode,6'b000110}, register 2 0xFF, register 3 0xC7, register 4 0x00, register 7 0x08.
- R10: outEnable[3:0] is register 0 bits {6,5,3,1}, slewFast[3:0] is register 2 bits {6,5,3,1}, and amplitude is register 1 bits 1:0. In each bit list the first bit goes to the output MSB.
- R11: sdaDriveLow is 0 in and right after reset, and it changes only in a cycle that follows a sample of SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; straps are captured while low |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line (wired level) |
| addrStrap | input | 2 | Encoded address strap (00 low, 01 mid, 10 high) |
| modeStrap | input | 2 | Encoded PLL-mode strap (00 low, 01 mid, 10 high) |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| outEnable | output | 4 | Per-output enable bits |
| slewFast | output | 4 | Per-output fast slew select |
| amplitude | output | 2 | Output amplitude code |
| pllMode | output | 2 | Active PLL operating mode |
| freqSel | output | 2 | Active frequency select |
| fbSlewFast | output | 1 | Feedback slew select |

## Verification
The properties assume a well-behaved master. SDA changes only while SCL is low, except for the start and stop edges. Each line stays at a level for several system clocks. The master never issues a stop or start while the slave is pulling SDA low. The bench's master task moves one line at a time, holds each level for five clocks, and NACKs a read before it stops. Random offsets, counts and data therefore stay inside these assumptions, and the directed cases add early stops, over-count bytes, foreign addresses and writes to read-only locations.

// File: rtl/cfgsmb_pkg.sv
package cfgsmb_pkg;

  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam logic [3:0] ADDR_HI = 4'b1101;
  localparam int CNT_IDX = 7;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIndex;
    logic [DATA_W-1:0] wrData;
    logic [IDX_W-1:0]  rdIndex;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_OFFS,
    ROLE_CNT,
    ROLE_DATA
  } rxRole_t;

  function automatic logic [2:0] strapAddrLow(input logic [1:0] code);
    case (code)
      2'b01:   return 3'b100;
      2'b10:   return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [1:0] strapModeBits(input logic [1:0] code);
    case (code)
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regWriteMask(input int idx);
    case (idx)
      0, 2:    return 8'h6A;
      1:       return 8'h3B;
      3:       return 8'h39;
      7:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regResetVal(input int idx, input logic [1:0] mode);
    case (idx)
      0, 2:    return 8'hFF;
      1:       return {mode, 6'b000110};
      3:       return 8'hC7;
      5:       return 8'h03;
      6:       return 8'h44;
      7:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgsmb_ctrl.sv
module cfgsmb_ctrl
  import cfgsmb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        addrLow,
  input  logic [DATA_W-1:0] countByte,
  input  logic [DATA_W-1:0] rdData,
  output regStrobe_t        strobe,
  output logic              sdaDriveLow
);

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] FULL_BYTE = BIT_W'(DATA_W);

  busState_t         state;
  rxRole_t           role;
  logic              sclPrev, sdaPrev;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  offsetReg, ptr;
  logic [DATA_W-1:0] remaining;
  logic              isRead, ackGiven, sdaOut;

  logic sclRise, sclFall, startSeen, stopSeen;
  logic addrMatch, ackDecision, byteDone;

  assign sclRise   = sclIn & ~sclPrev;
  assign sclFall   = ~sclIn & sclPrev;
  assign startSeen = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopSeen  = sclIn & sclPrev & ~sdaPrev & sdaIn;
  assign addrMatch = (shiftReg[7:1] == {ADDR_HI, addrLow});
  assign byteDone  = (state == ST_RX) && sclFall && (bitCnt == FULL_BYTE)
                     && !startSeen && !stopSeen;

  always_comb begin
    case (role)
      ROLE_ADDR: ackDecision = addrMatch;
      ROLE_DATA: ackDecision = (remaining != '0);
      default:   ackDecision = 1'b1;
    endcase
  end

  always_comb begin
    strobe.wrEn    = byteDone && (role == ROLE_DATA) && (remaining != '0);
    strobe.wrIndex = ptr;
    strobe.wrData  = shiftReg;
    strobe.rdIndex = ptr;
  end

  assign sdaDriveLow = sdaOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      role      <= ROLE_ADDR;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      bitCnt    <= '0;
      shiftReg  <= '0;
      offsetReg <= '0;
      ptr       <= '0;
      remaining <= '0;
      isRead    <= 1'b0;
      ackGiven  <= 1'b0;
      sdaOut    <= 1'b0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (startSeen) begin
        state  <= ST_RX;
        role   <= ROLE_ADDR;
        bitCnt <= '0;
        sdaOut <= 1'b0;
      end else if (stopSeen) begin
        state  <= ST_IDLE;
        sdaOut <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != FULL_BYTE) begin
              shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
              bitCnt   <= bitCnt + 1'b1;
            end else if (byteDone) begin
              sdaOut   <= ackDecision;
              ackGiven <= ackDecision;
              bitCnt   <= '0;
              state    <= ST_RXACK;
              case (role)
                ROLE_ADDR: if (addrMatch) isRead <= shiftReg[0];
                ROLE_OFFS: begin
                  offsetReg <= shiftReg;
                  ptr       <= shiftReg;
                end
                ROLE_CNT:  remaining <= shiftReg;
                default: begin
                  if (remaining != '0) begin
                    ptr       <= ptr + 1'b1;
                    remaining <= remaining - 1'b1;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              if (!ackGiven) begin
                sdaOut <= 1'b0;
                state  <= ST_IDLE;
              end else if (role == ROLE_ADDR && isRead) begin
                shiftReg <= countByte;
                sdaOut   <= ~countByte[DATA_W-1];
                ptr      <= offsetReg;
                bitCnt   <= '0;
                state    <= ST_TX;
              end else begin
                sdaOut <= 1'b0;
                state  <= ST_RX;
                case (role)
                  ROLE_ADDR: role <= ROLE_OFFS;
                  ROLE_OFFS: role <= ROLE_CNT;
                  default:   role <= ROLE_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == FULL_BYTE) begin
                sdaOut <= 1'b0;
                bitCnt <= '0;
                state  <= ST_TXACK;
              end else begin
                shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
                sdaOut   <= ~shiftReg[DATA_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise && sdaIn) begin
              state <= ST_IDLE;
            end else if (sclFall) begin
              shiftReg <= rdData;
              sdaOut   <= ~rdData[DATA_W-1];
              ptr      <= ptr + 1'b1;
              state    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgsmb_regs.sv
module cfgsmb_regs
  import cfgsmb_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addrStrap,
  input  logic [1:0]        modeStrap,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] countByte,
  output logic [2:0]        addrLow,
  output logic [3:0]        outEnable,
  output logic [3:0]        slewFast,
  output logic [1:0]        amplitude,
  output logic [1:0]        pllMode,
  output logic [1:0]        freqSel,
  output logic              fbSlewFast
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regBank;
  logic [2:0] addrLowQ;

  always_ff @(posedge clk) begin
    if (!rstN) addrLowQ <= strapAddrLow(addrStrap);
  end
  assign addrLow = addrLowQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = regWriteMask(i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= regResetVal(i, strapModeBits(modeStrap));
      else if (strobe.wrEn && strobe.wrIndex == IDX_W'(i))
        q <= (q & ~MASK) | (strobe.wrData & MASK);
    end
    assign regBank[i] = q;
  end

  always_comb begin
    if (int'(strobe.rdIndex) < NUM_REGS)
      rdData = regBank[strobe.rdIndex[SEL_W-1:0]];
    else
      rdData = '0;
  end

  assign countByte  = {3'b000, regBank[CNT_IDX][4:0]};
  assign outEnable  = {regBank[0][6], regBank[0][5], regBank[0][3], regBank[0][1]};
  assign slewFast   = {regBank[2][6], regBank[2][5], regBank[2][3], regBank[2][1]};
  assign amplitude  = regBank[1][1:0];
  assign pllMode    = regBank[1][5] ? regBank[1][4:3] : regBank[1][7:6];
  assign freqSel    = regBank[3][5] ? regBank[3][4:3] : 2'b00;
  assign fbSlewFast = regBank[3][0];

endmodule

// File: rtl/cfgsmb_slave.sv
module cfgsmb_slave
  import cfgsmb_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrStrap,
  input  logic [1:0] modeStrap,
  output logic       sdaDriveLow,
  output logic [3:0] outEnable,
  output logic [3:0] slewFast,
  output logic [1:0] amplitude,
  output logic [1:0] pllMode,
  output logic [1:0] freqSel,
  output logic       fbSlewFast
);

  regStrobe_t        strobe;
  logic [DATA_W-1:0] rdData, countByte;
  logic [2:0]        addrLow;

  cfgsmb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .addrLow    (addrLow),
    .countByte  (countByte),
    .rdData     (rdData),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  cfgsmb_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrap (addrStrap),
    .modeStrap (modeStrap),
    .strobe    (strobe),
    .rdData    (rdData),
    .countByte (countByte),
    .addrLow   (addrLow),
    .outEnable (outEnable),
    .slewFast  (slewFast),
    .amplitude (amplitude),
    .pllMode   (pllMode),
    .freqSel   (freqSel),
    .fbSlewFast(fbSlewFast)
  );

endmodule

// File: rtl/cfgsmb_chk.sv
module cfgsmb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaIn,
  input logic       sdaDriveLow,
  input logic [3:0] outEnable,
  input logic [3:0] slewFast,
  input logic [1:0] amplitude,
  input logic [1:0] pllMode,
  input logic [1:0] freqSel,
  input logic       fbSlewFast
);

  logic [14:0] cfgVec;
  logic        sclQ, sdaQ, stopSeen, rstWasLow;

  assign cfgVec   = {outEnable, slewFast, amplitude, pllMode, freqSel, fbSlewFast};
  assign stopSeen = sclQ && sclIn && !sdaQ && sdaIn;

  always_ff @(posedge clk) begin
    sclQ <= sclIn;
    sdaQ <= sdaIn;
    if (!rstN) begin
      rstWasLow <= 1'b1;
    end else begin
      rstWasLow <= 1'b0;
      if (rstWasLow) begin
        AST_RESET_QUIET: assert (!sdaDriveLow); // R11
      end
    end
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !$past(sclIn)); // R11

  AST_CFG_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgVec) |-> ($past(sclIn, 2) && !$past(sclIn))); // R2

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaDriveLow); // R5

endmodule

bind cfgsmb_slave cfgsmb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaIn      (sdaIn),
  .sdaDriveLow(sdaDriveLow),
  .outEnable  (outEnable),
  .slewFast   (slewFast),
  .amplitude  (amplitude),
  .pllMode    (pllMode),
  .freqSel    (freqSel),
  .fbSlewFast (fbSlewFast)
);

// File: tb/cfgsmb_slave_tb.sv
module cfgsmb_slave_tb;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] addrStrap = 2'b00, modeStrap = 2'b00;
  logic sdaDriveLow, fbSlewFast, sdaLine;
  logic [3:0] outEnable, slewFast;
  logic [1:0] amplitude, pllMode, freqSel;

  int total = 0;
  int bad = 0;
  logic [7:0] model [8];
  logic [6:0] myAddr;

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  cfgsmb_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .addrStrap(addrStrap), .modeStrap(modeStrap), .sdaDriveLow(sdaDriveLow),
    .outEnable(outEnable), .slewFast(slewFast), .amplitude(amplitude),
    .pllMode(pllMode), .freqSel(freqSel), .fbSlewFast(fbSlewFast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int idx);
    case (idx)
      0: return 8'h6A; 1: return 8'h3B; 2: return 8'h6A; 3: return 8'h39; 7: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] modelRead(input int idx);
    return (idx < 8) ? model[idx] : 8'h00;
  endfunction

  task automatic modelWrite(input int idx, input logic [7:0] d);
    if (idx < 8) model[idx] = (model[idx] & ~maskOf(idx)) | (d & maskOf(idx));
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic v);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); v = sdaLine; sclM = 1'b0; waitQ();
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    logic v;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(v);
    ackd = ~v;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      getBit(v);
      b[i] = v;
    end
    putBit(~ackIt);
  endtask

  task automatic doReset(input logic [1:0] aCode, input logic [1:0] mCode);
    logic [1:0] mb;
    rstN = 1'b0; addrStrap = aCode; modeStrap = mCode;
    sclM = 1'b1; sdaM = 1'b1;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    case (aCode) 2'b01: myAddr = 7'b1101100; 2'b10: myAddr = 7'b1101101; default: myAddr = 7'b1101011; endcase
    case (mCode) 2'b01: mb = 2'b01; 2'b10: mb = 2'b11; default: mb = 2'b00; endcase
    model[0] = 8'hFF; model[1] = {mb, 6'b000110}; model[2] = 8'hFF; model[3] = 8'hC7;
    model[4] = 8'h00; model[5] = 8'h03; model[6] = 8'h44; model[7] = 8'h08;
  endtask

  task automatic checkOutputs(input string tag);
    logic [1:0] expMode, expFreq;
    check(outEnable == {model[0][6], model[0][5], model[0][3], model[0][1]}, {tag, " R10 outEnable"},
          outEnable, {model[0][6], model[0][5], model[0][3], model[0][1]});
    check(slewFast == {model[2][6], model[2][5], model[2][3], model[2][1]}, {tag, " R10 slewFast"},
          slewFast, {model[2][6], model[2][5], model[2][3], model[2][1]});
    check(amplitude == model[1][1:0], {tag, " R10 amplitude"}, amplitude, model[1][1:0]);
    expMode = model[1][5] ? model[1][4:3] : model[1][7:6];
    check(pllMode == expMode, {tag, " R7 pllMode"}, pllMode, expMode);
    expFreq = model[3][5] ? model[3][4:3] : 2'b00;
    check(freqSel == expFreq, {tag, " R8 freqSel"}, freqSel, expFreq);
    check(fbSlewFast == model[3][0], {tag, " R8 fbSlewFast"}, fbSlewFast, model[3][0]);
  endtask

  // Sends nSend data bytes; stops early on the first NACK.
  task automatic blockWrite(input logic [7:0] off, input logic [7:0] cnt, input int nSend,
                            input logic [63:0] dPack);
    logic ackd;
    startCond();
    sendByte({myAddr, 1'b0}, ackd);
    check(ackd, "R1 address ack on write", ackd, 1);
    sendByte(off, ackd);
    check(ackd, "R2 offset ack", ackd, 1);
    sendByte(cnt, ackd);
    check(ackd, "R2 count ack", ackd, 1);
    for (int i = 0; i < nSend; i++) begin
      sendByte(dPack[8*i +: 8], ackd);
      if (i < int'(cnt)) begin
        check(ackd, "R2 data ack", ackd, 1);
        modelWrite(int'(off) + i, dPack[8*i +: 8]);
      end else begin
        check(!ackd, "R3 over-count byte nack", ackd, 0);
        break;
      end
    end
    stopCond();
  endtask

  // Reads up to limit data bytes after the count byte.
  task automatic blockRead(input logic [7:0] off, input int limit);
    logic ackd;
    logic [7:0] b;
    int expCnt, nRead;
    startCond();
    sendByte({myAddr, 1'b0}, ackd);
    check(ackd, "R1 address ack before read", ackd, 1);
    sendByte(off, ackd);
    check(ackd, "R4 offset ack", ackd, 1);
    startCond();
    sendByte({myAddr, 1'b1}, ackd);
    check(ackd, "R4 read address ack", ackd, 1);
    expCnt = int'(model[7][4:0]);
    nRead = (limit < expCnt) ? limit : expCnt;
    recvByte(b, nRead != 0);
    check(b == 8'(expCnt), "R4 count byte", b, expCnt);
    for (int i = 0; i < nRead; i++) begin
      recvByte(b, i != nRead - 1);
      check(b == modelRead(int'(off) + i), "R4 R6 R9 read data", b, modelRead(int'(off) + i));
    end
    stopCond();
    check(!sdaDriveLow, "R5 released after stop", sdaDriveLow, 0);
  endtask

  initial begin
    logic ackd;
    int seedDummy;
    seedDummy = $urandom(32'h1d2c);
    for (int s = 0; s < 4; s++) begin
      doReset(2'(s), 2'(s));
      check(!sdaDriveLow, "R11 idle after reset", sdaDriveLow, 0);
      checkOutputs("reset");
      startCond();
      sendByte({7'b1101111, 1'b0}, ackd);
      check(!ackd, "R1 foreign address nack", ackd, 0);
      sendByte(8'h00, ackd);
      check(!ackd, "R1 ignored until next start", ackd, 0);
      stopCond();
      checkOutputs("R1 after foreign");
      blockRead(8'h00, 8);
    end

    doReset(2'b01, 2'b01);
    blockWrite(8'h00, 8'd4, 4, {32'h0, 8'h11, 8'h00, 8'h00, 8'h00});
    checkOutputs("R2 R9 first write");
    blockRead(8'h00, 8);
    blockWrite(8'h01, 8'd1, 1, {56'h0, 8'h28});
    checkOutputs("R7 sw mode");
    blockWrite(8'h03, 8'd1, 1, {56'h0, 8'h30});
    checkOutputs("R8 freq");
    blockWrite(8'h04, 8'd4, 4, {8'h05, 8'hFF, 8'hFF, 8'hFF});
    blockRead(8'h03, 8);
    blockWrite(8'h09, 8'd2, 2, {48'h0, 8'h12, 8'h34});
    blockRead(8'h08, 2);
    blockWrite(8'h00, 8'd2, 3, {40'h0, 8'h55, 8'hFF, 8'hFF});
    checkOutputs("R3 over count");
    blockRead(8'h00, 5);
    blockWrite(8'h00, 8'd3, 1, {56'h0, 8'h00});
    checkOutputs("R5 early stop");
    blockRead(8'h01, 2);
    blockRead(8'h00, 8);

    for (int it = 0; it < 20; it++) begin
      logic [7:0] off, cnt;
      logic [63:0] d;
      int nSend;
      off = 8'($urandom_range(0, 9));
      cnt = 8'($urandom_range(0, 4));
      nSend = int'(cnt) + int'($urandom_range(0, 1));
      d = {$urandom(), $urandom()};
      for (int k = 0; k < 8; k++)
        if (int'(off) + k == 7) d[8*k +: 8] = 8'($urandom_range(0, 10));
      blockWrite(off, cnt, nSend, d);
      checkOutputs("random");
      blockRead(8'($urandom_range(0, 9)), 12);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule